// File: doc/BRIEF.md
# Firmware Image Integrity Checker

This block inspects a firmware image as it streams past, one byte per clock, and decides whether the image may be loaded. A one-cycle `start` pulse samples the total image length. The image bytes then follow on `in_byte`, each qualified by `in_valid`. While the bytes arrive, the block runs a CRC-16 over the body of the image. It follows a 16-bit pointer to a header that lies deeper in the image, and from that header it captures the offset and size of an instruction section and of a data section. It also picks out the first character of a version string, which is placed relative to the data section.

Each check is done in a single pass, with no store of the image. The only storage is a small buffer that holds the header bytes. When the final byte has been consumed, the block compares every extracted field against the image length. It then issues one `done` pulse together with a pass flag, an error code and the absolute placement of both sections. These outputs are registered and keep their values until the next image completes.

Top module: `fw_image_check`

## Requirements
- R1: A CRC-16 (polynomial 0x1021, most significant bit first, initial value 0) is computed over every byte except the last two. Byte len-2 holds the upper half of the expected value and byte len-1 holds the lower half. A mismatch gives error code 1.
- R2: Byte 8 (low) and byte 9 (high) form a pointer, and the base offset equals the pointer shifted left by 12. An image shorter than 10 bytes gives error code 2.
- R3: The header starts at base + 0x300. It holds four consecutive 3-byte little-endian fields in this order: instruction offset, instruction size, data offset, data size. When base + 0x30C exceeds the image length, the result is error code 3.
- R4: At `done`, `iram_off` and `dram_off` carry base + the section offset, and `iram_size` and `dram_size` carry the sizes as read.
- R5: A section size that is not a multiple of 4 gives error code 4.
- R6: An absolute offset plus size that exceeds the image length, for either section, gives error code 5.
- R7: The version string is 64 bytes long and starts at data absolute offset + 0x200. It must fit inside the image, its first byte must be nonzero, and that byte must arrive after the last header byte. Otherwise the result is error code 6.
- R8: When several errors apply, the lowest code is reported. `pass` is high exactly when the code is 0.
- R9: `done` is high for one cycle, exactly two clock edges after the edge that accepts the last byte. Cycles with `in_valid` low only pause the stream.
- R10: Outputs change only in the cycle where `done` is high. Bytes presented after an image has ended, or before any `start`, have no effect.
- R11: A `start` pulse abandons any image in progress. A length below 2 completes without consuming bytes, with `done` two edges after `start` and error code 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a new image and samples `img_len` |
| img_len | input | LEN_W | Total image length in bytes |
| in_valid | input | 1 | Qualifies `in_byte` |
| in_byte | input | 8 | Image byte |
| done | output | 1 | One-cycle result strobe |
| pass | output | 1 | Image accepted |
| err_code | output | 3 | 0 ok, 1 CRC, 2 pointer, 3 header, 4 alignment, 5 bounds, 6 version |
| iram_off | output | LEN_W | Absolute instruction-section offset |
| iram_size | output | 24 | Instruction-section size |
| dram_off | output | LEN_W | Absolute data-section offset |
| dram_size | output | 24 | Data-section size |

## Verification
The assertions check the following properties on every cycle:
- `done` is a single-cycle pulse that follows the internal completion flag.
- The byte position never passes the sampled length.
- The header is captured only after the pointer, and the version byte only after the header.
- The results hold steady between strobes.
- A passing result never carries a misaligned size.

Only the bench scenarios can show the rest. This covers the error code produced for each kind of defect, the priority between defects that occur together, the base shift applied to the section offsets, the exact latency of the strobe, and the fact that bytes after an image ends are ignored.

// File: rtl/fwic_pkg.sv
package fwic_pkg;

  typedef enum logic [2:0] {
    ERR_NONE  = 3'd0,
    ERR_CRC   = 3'd1,
    ERR_PTR   = 3'd2,
    ERR_HDR   = 3'd3,
    ERR_ALIGN = 3'd4,
    ERR_BOUND = 3'd5,
    ERR_VER   = 3'd6
  } fwic_err_e;

  localparam int PTR_AT     = 8;       // low pointer byte position
  localparam int PTR_SHIFT  = 12;
  localparam int HDR_REL    = 'h300;   // header distance from base
  localparam int FLD_W      = 24;
  localparam int FLD_BYTES  = FLD_W / 8;
  localparam int NUM_FLD    = 4;
  localparam int HDR_BYTES  = FLD_BYTES * NUM_FLD;
  localparam int VER_REL    = 'h200;   // version distance from data section
  localparam int VER_LEN    = 64;
  localparam logic [15:0] CRC_POLY = 16'h1021;

  // one byte of CRC-16, bit-serial, msb first
  function automatic logic [15:0] crc16_step(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    logic        fb;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      fb = r[15] ^ b[i];
      r  = {r[14:0], 1'b0};
      if (fb) r = r ^ CRC_POLY;
    end
    return r;
  endfunction

endpackage

// File: rtl/fwic_crc.sv
module fwic_crc
  import fwic_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        clr,
  input  logic        body_en,
  input  logic        trl_hi_en,
  input  logic        trl_lo_en,
  input  logic [7:0]  din,
  output logic [15:0] crc,
  output logic [15:0] trailer
);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      crc     <= '0;
      trailer <= '0;
    end else begin
      if (body_en)   crc           <= crc16_step(crc, din);
      if (trl_hi_en) trailer[15:8] <= din;
      if (trl_lo_en) trailer[7:0]  <= din;
    end
  end

  // R1
  trailer_freezes_crc_chk: assert property (@(posedge clk) disable iff (rst)
    (trl_hi_en && !clr) |=> $stable(crc));

endmodule

// File: rtl/fwic_locate.sv
module fwic_locate
  import fwic_pkg::*;
#(
  parameter int LEN_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             byte_en,
  input  logic [LEN_W-1:0] pos,
  input  logic [7:0]       din,
  output logic [LEN_W-1:0] base,
  output logic [LEN_W-1:0] hdr_start,
  output logic [FLD_W-1:0] i_off,
  output logic [FLD_W-1:0] i_sz,
  output logic [FLD_W-1:0] d_off,
  output logic [FLD_W-1:0] d_sz,
  output logic [LEN_W-1:0] ver_pos,
  output logic             hdr_done,
  output logic             ver_seen,
  output logic [7:0]       ver_byte
);

  localparam int IDX_W = $clog2(HDR_BYTES);
  localparam int BUF_D = 1 << IDX_W;

  logic [15:0]      ptr_q;
  logic             ptr_done;
  logic [7:0]       hdr_buf [BUF_D];
  logic [IDX_W-1:0] hdr_idx;
  logic             in_hdr;
  logic [FLD_W-1:0] fld [NUM_FLD];

  assign base      = LEN_W'({ptr_q, {PTR_SHIFT{1'b0}}});
  assign hdr_start = base + LEN_W'(HDR_REL);
  assign hdr_idx   = IDX_W'(pos - hdr_start);
  assign in_hdr    = byte_en && ptr_done && (pos >= hdr_start) &&
                     (pos < hdr_start + LEN_W'(HDR_BYTES));

  // pointer capture
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      ptr_q    <= '0;
      ptr_done <= 1'b0;
    end else if (byte_en) begin
      if (pos == LEN_W'(PTR_AT))     ptr_q[7:0]  <= din;
      if (pos == LEN_W'(PTR_AT + 1)) begin
        ptr_q[15:8] <= din;
        ptr_done    <= 1'b1;
      end
    end
  end

  // header byte buffer, no reset so it maps to distributed RAM
  always_ff @(posedge clk) begin
    if (in_hdr) hdr_buf[hdr_idx] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) hdr_done <= 1'b0;
    else if (in_hdr && hdr_idx == IDX_W'(HDR_BYTES - 1)) hdr_done <= 1'b1;
  end

  // little-endian 24-bit field decode, zero until the header is complete
  for (genvar f = 0; f < NUM_FLD; f++) begin : g_fld
    always_comb begin
      fld[f] = '0;
      if (hdr_done)
        for (int k = 0; k < FLD_BYTES; k++)
          fld[f][8*k +: 8] = hdr_buf[f*FLD_BYTES + k];
    end
  end

  assign i_off = fld[0];
  assign i_sz  = fld[1];
  assign d_off = fld[2];
  assign d_sz  = fld[3];

  assign ver_pos = base + LEN_W'(d_off) + LEN_W'(VER_REL);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      ver_seen <= 1'b0;
      ver_byte <= '0;
    end else if (byte_en && hdr_done && !ver_seen && pos == ver_pos) begin
      ver_seen <= 1'b1;
      ver_byte <= din;
    end
  end

  // R3
  hdr_after_ptr_chk: assert property (@(posedge clk) disable iff (rst)
    hdr_done |-> ptr_done);

  // R7
  ver_after_hdr_chk: assert property (@(posedge clk) disable iff (rst)
    ver_seen |-> hdr_done);

endmodule

// File: rtl/fwic_judge.sv
module fwic_judge
  import fwic_pkg::*;
#(
  parameter int LEN_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fin,
  input  logic             short_img,
  input  logic [LEN_W-1:0] len,
  input  logic [15:0]      crc,
  input  logic [15:0]      trailer,
  input  logic [LEN_W-1:0] base,
  input  logic [LEN_W-1:0] hdr_start,
  input  logic [FLD_W-1:0] i_off,
  input  logic [FLD_W-1:0] i_sz,
  input  logic [FLD_W-1:0] d_off,
  input  logic [FLD_W-1:0] d_sz,
  input  logic [LEN_W-1:0] ver_pos,
  input  logic             ver_seen,
  input  logic [7:0]       ver_byte,
  output logic             done,
  output logic             pass,
  output logic [2:0]       err_code,
  output logic [LEN_W-1:0] iram_off,
  output logic [FLD_W-1:0] iram_size,
  output logic [LEN_W-1:0] dram_off,
  output logic [FLD_W-1:0] dram_size
);

  localparam int SUM_W = LEN_W + 2;

  logic [SUM_W-1:0] lenx;
  logic [LEN_W-1:0] i_abs, d_abs;
  logic e_crc, e_ptr, e_hdr, e_aln, e_bnd, e_ver;
  fwic_err_e code;

  assign lenx  = SUM_W'(len);
  assign i_abs = base + LEN_W'(i_off);
  assign d_abs = base + LEN_W'(d_off);

  assign e_crc = short_img || (crc != trailer);
  assign e_ptr = len < LEN_W'(PTR_AT + 2);
  assign e_hdr = (SUM_W'(hdr_start) + SUM_W'(HDR_BYTES)) > lenx;
  assign e_aln = (|i_sz[1:0]) || (|d_sz[1:0]);
  assign e_bnd = ((SUM_W'(i_abs) + SUM_W'(i_sz)) > lenx) ||
                 ((SUM_W'(d_abs) + SUM_W'(d_sz)) > lenx);
  assign e_ver = ((SUM_W'(ver_pos) + SUM_W'(VER_LEN)) > lenx) ||
                 !ver_seen || (ver_byte == 8'h00);

  always_comb begin
    if      (e_crc) code = ERR_CRC;
    else if (e_ptr) code = ERR_PTR;
    else if (e_hdr) code = ERR_HDR;
    else if (e_aln) code = ERR_ALIGN;
    else if (e_bnd) code = ERR_BOUND;
    else if (e_ver) code = ERR_VER;
    else            code = ERR_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done      <= 1'b0;
      pass      <= 1'b0;
      err_code  <= '0;
      iram_off  <= '0;
      iram_size <= '0;
      dram_off  <= '0;
      dram_size <= '0;
    end else begin
      done <= fin;
      if (fin) begin
        err_code  <= code;
        pass      <= (code == ERR_NONE);
        iram_off  <= i_abs;
        iram_size <= i_sz;
        dram_off  <= d_abs;
        dram_size <= d_sz;
      end
    end
  end

  // R10
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(err_code) && $stable(pass) && $stable(iram_off) &&
               $stable(dram_off) && $stable(iram_size) && $stable(dram_size)));

  // R5
  aligned_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (done && pass) |-> (iram_size[1:0] == 2'b00 && dram_size[1:0] == 2'b00));

endmodule

// File: rtl/fw_image_check.sv
module fw_image_check
  import fwic_pkg::*;
#(
  parameter int LEN_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [LEN_W-1:0] img_len,
  input  logic             in_valid,
  input  logic [7:0]       in_byte,
  output logic             done,
  output logic             pass,
  output logic [2:0]       err_code,
  output logic [LEN_W-1:0] iram_off,
  output logic [23:0]      iram_size,
  output logic [LEN_W-1:0] dram_off,
  output logic [23:0]      dram_size
);

  logic             active_q, fin_q, short_q;
  logic [LEN_W-1:0] pos_q, len_q;
  logic             byte_en, last_byte;
  logic [15:0]      crc, trailer;
  logic [LEN_W-1:0] base, hdr_start, ver_pos;
  logic [FLD_W-1:0] i_off, i_sz, d_off, d_sz;
  logic             hdr_done, ver_seen;
  logic [7:0]       ver_byte;

  assign byte_en   = active_q && in_valid && !start;
  assign last_byte = (pos_q == len_q - LEN_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      fin_q    <= 1'b0;
      short_q  <= 1'b0;
      pos_q    <= '0;
      len_q    <= '0;
    end else begin
      fin_q <= 1'b0;
      if (start) begin
        len_q    <= img_len;
        pos_q    <= '0;
        active_q <= (img_len >= LEN_W'(2));
        short_q  <= (img_len <  LEN_W'(2));
        fin_q    <= (img_len <  LEN_W'(2));
      end else if (byte_en) begin
        pos_q <= pos_q + LEN_W'(1);
        if (last_byte) begin
          active_q <= 1'b0;
          fin_q    <= 1'b1;
        end
      end
    end
  end

  fwic_crc u_crc (
    .clk       (clk),
    .rst       (rst),
    .clr       (start),
    .body_en   (byte_en && (pos_q < len_q - LEN_W'(2))),
    .trl_hi_en (byte_en && (pos_q == len_q - LEN_W'(2))),
    .trl_lo_en (byte_en && last_byte),
    .din       (in_byte),
    .crc       (crc),
    .trailer   (trailer)
  );

  fwic_locate #(.LEN_W(LEN_W)) u_locate (
    .clk       (clk),
    .rst       (rst),
    .clr       (start),
    .byte_en   (byte_en),
    .pos       (pos_q),
    .din       (in_byte),
    .base      (base),
    .hdr_start (hdr_start),
    .i_off     (i_off),
    .i_sz      (i_sz),
    .d_off     (d_off),
    .d_sz      (d_sz),
    .ver_pos   (ver_pos),
    .hdr_done  (hdr_done),
    .ver_seen  (ver_seen),
    .ver_byte  (ver_byte)
  );

  fwic_judge #(.LEN_W(LEN_W)) u_judge (
    .clk       (clk),
    .rst       (rst),
    .fin       (fin_q),
    .short_img (short_q),
    .len       (len_q),
    .crc       (crc),
    .trailer   (trailer),
    .base      (base),
    .hdr_start (hdr_start),
    .i_off     (i_off),
    .i_sz      (i_sz),
    .d_off     (d_off),
    .d_sz      (d_sz),
    .ver_pos   (ver_pos),
    .ver_seen  (ver_seen),
    .ver_byte  (ver_byte),
    .done      (done),
    .pass      (pass),
    .err_code  (err_code),
    .iram_off  (iram_off),
    .iram_size (iram_size),
    .dram_off  (dram_off),
    .dram_size (dram_size)
  );

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9
  done_source_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(fin_q));

  // R10
  pos_bound_chk: assert property (@(posedge clk) disable iff (rst)
    active_q |-> (pos_q < len_q));

endmodule

// File: tb/fw_image_check_tb.sv
`timescale 1ns/1ps
module fw_image_check_tb;

  typedef struct packed {
    logic [31:0] ptr;
    logic [31:0] ioff;
    logic [31:0] isz;
    logic [31:0] doff;
    logic [31:0] dsz;
    logic [31:0] ver;
    logic [31:0] len;
    logic [31:0] bad;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{0, 'h310, 8,     'h320, 4,     'h41, 'h562,  0, 0}, // good
    '{0, 'h310, 8,     'h320, 4,     'h41, 'h562,  1, 1}, // crc
    '{0, 'h310, 8,     'h320, 4,     'h41, 9,      0, 2}, // too short for pointer
    '{0, 'h310, 8,     'h320, 4,     'h41, 'h305,  0, 3}, // header cut off
    '{0, 'h310, 6,     'h320, 4,     'h41, 'h562,  0, 4}, // misaligned
    '{0, 'h310, 8,     'h320, 'h400, 'h41, 'h562,  0, 5}, // data out of bounds
    '{0, 'h310, 8,     'h320, 4,     'h00, 'h562,  0, 6}, // empty version
    '{0, 'h310, 8,     'h000, 4,     'h41, 'h562,  0, 6}, // version before header
    '{1, 'h310, 8,     'h320, 4,     'h56, 'h1562, 0, 0}, // shifted base
    '{0, 'h310, 8,     'h320, 4,     'h41, 'h550,  0, 6}, // version region too long
    '{0, 'h600, 'h100, 'h320, 4,     'h41, 'h562,  0, 5}, // instruction out of bounds
    '{0, 'h310, 6,     'h320, 'h400, 'h41, 'h562,  0, 4}, // align beats bounds
    '{0, 'h310, 6,     'h320, 4,     'h41, 'h562,  1, 1}  // crc beats align
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] img_len = '0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_byte = '0;
  logic        done, pass;
  logic [2:0]  err_code;
  logic [31:0] iram_off, dram_off;
  logic [23:0] iram_size, dram_size;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  fw_image_check #(.LEN_W(32)) u_dut (
    .clk(clk), .rst(rst), .start(start), .img_len(img_len),
    .in_valid(in_valid), .in_byte(in_byte), .done(done), .pass(pass),
    .err_code(err_code), .iram_off(iram_off), .iram_size(iram_size),
    .dram_off(dram_off), .dram_size(dram_size)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
    end
  endtask

  function automatic logic [15:0] tb_crc(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] x;
    x = c ^ {b, 8'h00};
    repeat (8) x = x[15] ? ((x << 1) ^ 16'h1021) : (x << 1);
    return x;
  endfunction

  function automatic string req_of(input int code);
    case (code)
      1: return "R1";
      2: return "R2";
      3: return "R3";
      4: return "R5";
      5: return "R6";
      6: return "R7";
      default: return "R4";
    endcase
  endfunction

  function automatic logic [7:0] body_byte(input vec_t v, input int i);
    int base, h, vp, k, f;
    logic [31:0] fv;
    logic [7:0] b;
    base = int'(v.ptr) << 12;
    h    = base + 'h300;
    vp   = base + int'(v.doff) + 'h200;
    b    = 8'((i * 7) + 3);
    if (i == 8) b = v.ptr[7:0];
    if (i == 9) b = v.ptr[15:8];
    if (i >= h && i < h + 12) begin
      k = i - h;
      f = k / 3;
      fv = (f == 0) ? v.ioff : (f == 1) ? v.isz : (f == 2) ? v.doff : v.dsz;
      b = 8'(fv >> (8 * (k % 3)));
    end
    if (i == vp) b = v.ver[7:0];
    return b;
  endfunction

  // streams one image; gap inserts idle cycles; stop_at abandons early
  task automatic send(input vec_t v, input bit gap, input int stop_at);
    logic [15:0] c;
    logic [15:0] cw;
    logic [7:0]  b;
    int n;
    c = '0;
    n = int'(v.len);
    @(negedge clk);
    start = 1'b1;
    img_len = v.len;
    for (int i = 0; i < n && i < stop_at; i++) begin
      if (gap && (i % 5 == 2)) begin
        @(negedge clk);
        start = 1'b0;
        in_valid = 1'b0;
      end
      if (i < n - 2) begin
        b = body_byte(v, i);
        c = tb_crc(c, b);
      end else begin
        cw = c ^ ((v.bad != 0) ? 16'h0001 : 16'h0000);
        b = (i == n - 2) ? cw[15:8] : cw[7:0];
      end
      @(negedge clk);
      start = 1'b0;
      in_valid = 1'b1;
      in_byte = b;
    end
    @(negedge clk);
    start = 1'b0;
    in_valid = 1'b0;
  endtask

  // after the final byte edge: done must appear on the second edge, one cycle wide
  task automatic finish_and_check(input vec_t v, input string tag);
    int expc;
    expc = int'(v.exp);
    chk(done == 1'b0, "R9", longint'(done), 0);
    @(negedge clk);
    chk(done == 1'b1, "R9", longint'(done), 1);
    chk(err_code == 3'(expc), req_of(expc), longint'(err_code), longint'(expc));
    // R8 pass flag
    chk(pass == (expc == 0), "R8", longint'(pass), longint'(expc == 0));
    if (expc != 2 && expc != 3) begin
      // R4 absolute placement
      chk(iram_off == (v.ptr << 12) + v.ioff, "R4", longint'(iram_off), longint'((v.ptr << 12) + v.ioff));
      chk(dram_off == (v.ptr << 12) + v.doff, "R4", longint'(dram_off), longint'((v.ptr << 12) + v.doff));
      chk(iram_size == v.isz[23:0] && dram_size == v.dsz[23:0], "R4",
          longint'({iram_size, dram_size}), longint'({v.isz[23:0], v.dsz[23:0]}));
    end
    @(negedge clk);
    chk(done == 1'b0, "R9", longint'(done), 0);
    if (tag.len() > 0) $display("vector %s done", tag);
  endtask

  initial begin
    #(600000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog R9 actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [2:0] held;
    repeat (3) @(negedge clk);
    // reset state (R10)
    chk(done == 1'b0 && pass == 1'b0 && err_code == 3'd0, "R10",
        longint'({done, pass, err_code}), 0);
    rst = 1'b0;
    // bytes before any start are ignored (R10)
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_byte = 8'(i);
    end
    @(negedge clk);
    in_valid = 1'b0;
    chk(done == 1'b0 && err_code == 3'd0, "R10", longint'({done, err_code}), 0);

    // table walk
    for (int t = 0; t < NV; t++) begin
      send(VECS[t], 1'b0, 1 << 30);
      finish_and_check(VECS[t], "");
    end

    // paused stream (R9)
    send(VECS[0], 1'b1, 1 << 30);
    finish_and_check(VECS[0], "");

    // bad image left in outputs, then stray bytes after end (R10)
    send(VECS[1], 1'b0, 1 << 30);
    finish_and_check(VECS[1], "");
    held = err_code;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_byte = 8'h5A;
      chk(done == 1'b0, "R10", longint'(done), 0);
    end
    @(negedge clk);
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk(err_code == held && done == 1'b0, "R10", longint'(err_code), longint'(held));

    // restart mid-image (R11)
    send(VECS[1], 1'b0, 300);
    send(VECS[0], 1'b0, 1 << 30);
    finish_and_check(VECS[0], "");

    // length below two (R11)
    @(negedge clk);
    start = 1'b1;
    img_len = 32'd1;
    @(negedge clk);
    start = 1'b0;
    chk(done == 1'b0, "R11", longint'(done), 0);
    @(negedge clk);
    chk(done == 1'b1 && err_code == 3'd1, "R11", longint'({done, err_code}), longint'({1'b1, 3'd1}));
    @(negedge clk);
    chk(done == 1'b0, "R11", longint'(done), 0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule